// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This block computes 32-bit integer products and quotients one bit per clock. It handles signed and unsigned operands and reuses a single adder for both jobs. A request is made by pulsing `start` with an operation code and two operands. The unit then works on a 64-bit accumulator: shift-and-add for multiplication, restoring subtraction for division. When it finishes, it writes the result into a pair of 32-bit result registers, `hi` and `lo`. These registers are always visible at the ports and keep their old contents while a new operation is running.

Signed operations work on the magnitudes of the operands. One extra cycle at the end then applies the sign. Nothing is flagged for overflow or for a zero divisor. A zero divisor takes the normal number of cycles and leaves whatever the restoring steps produce. `busy` covers the whole operation, and `done` marks the single cycle in which new results first appear.

Top module: `muldiv_unit`

## Requirements
- R1: `op` selects the operation: 0 = signed multiply, 1 = unsigned multiply, 2 = signed divide, 3 = unsigned divide. A `start` pulse is accepted whenever the unit is not busy.
- R2: An unsigned multiply leaves the upper 32 bits of the 64-bit product in `hi` and the lower 32 bits in `lo`.
- R3: A signed multiply leaves the full 64-bit two's-complement product in `hi`:`lo`. The unit negates the magnitude product when the operand signs differ.
- R4: An unsigned divide leaves the quotient in `lo` and the remainder in `hi`.
- R5: A signed divide truncates the quotient toward zero and gives the remainder the sign of the dividend. For example, the most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R6: A zero divisor raises no error. Unsigned: `lo` = 0xFFFFFFFF and `hi` = dividend. Signed: `hi` = dividend, and `lo` = 0xFFFFFFFF if the dividend is non-negative, otherwise 1.
- R7: `done` is high for exactly one cycle. Counting the clock edge that accepts `start` as edge 1, it is high in the cycle after edge 33 for unsigned operations and after edge 34 for signed operations.
- R8: `busy` is high from the cycle after `start` is accepted until the result is written. `busy` is low whenever `done` is high.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running operation keeps its operands, opcode and latency.
- R10: `hi` and `lo` keep their previous values until an operation completes, and they change only in a cycle where `done` is high.
- R11: A `start` given in the same cycle that `done` is high is accepted, so operations can run back to back.
- R12: After reset, `hi` and `lo` are zero and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| op | input | 2 | Operation code (see R1) |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | Upper product half or remainder |
| lo | output | 32 | Lower product half or quotient |

## Verification
Two events can land in the same cycle: completion of one operation (`done` high, results written) and acceptance of the next `start`. The bench issues each new request at the falling edge where it first sees `done`, so nearly every operation in the random stream starts in the previous one's completion cycle. It then checks that `busy` rises on the next edge, that the results just written match the expected values, and that the latency of the new operation is unchanged. A second overlap, `start` arriving mid-operation, is provoked with a different opcode and operands. It is judged by the final result and the latency.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MULS = 2'd0,
        OP_MULU = 2'd1,
        OP_DIVS = 2'd2,
        OP_DIVU = 2'd3
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } md_state_e;

endpackage

// File: rtl/muldiv_abs.sv
module muldiv_abs #(
    parameter int W = 32
) (
    input  logic         en_signed,
    input  logic [W-1:0] val,
    output logic [W-1:0] mag,
    output logic         neg
);
    always_comb begin
        neg = en_signed & val[W-1];
        mag = neg ? (~val + W'(1)) : val;
    end
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
    parameter int W = 32
) (
    input  logic           is_div,
    input  logic [2*W-1:0] acc_i,
    input  logic [W-1:0]   opnd,
    output logic [2*W-1:0] acc_o
);
    localparam int AW = W + 2;

    logic [AW-1:0] opa_w, opb_w, sum_w;
    logic          cin_w;

    // one shared adder: add for multiply, subtract for divide
    always_comb begin
        if (is_div) begin
            opa_w = {1'b0, acc_i[2*W-1:W-1]};
            opb_w = ~{2'b00, opnd};
            cin_w = 1'b1;
        end else begin
            opa_w = {2'b00, acc_i[2*W-1:W]};
            opb_w = acc_i[0] ? {2'b00, opnd} : '0;
            cin_w = 1'b0;
        end
        sum_w = opa_w + opb_w + AW'(cin_w);
    end

    always_comb begin
        if (is_div) begin
            if (sum_w[AW-1])
                acc_o = {acc_i[2*W-2:0], 1'b0};
            else
                acc_o = {sum_w[W-1:0], acc_i[W-2:0], 1'b1};
        end else begin
            acc_o = {sum_w[W:0], acc_i[W-1:1]};
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    localparam int CW = $clog2(W) + 1;

    typedef struct packed {
        md_state_e      st;
        logic [CW-1:0]  cnt;
        logic           is_div;
        logic           is_sgn;
        logic           neg_lo;
        logic           neg_hi;
        logic [W-1:0]   opnd;
        logic [2*W-1:0] acc;
        logic [W-1:0]   hi;
        logic [W-1:0]   lo;
        logic           done;
    } md_reg_t;

    md_reg_t r_q, r_d;

    logic           sgn_req;
    logic [W-1:0]   mag_a, mag_b;
    logic           neg_a, neg_b;
    logic [2*W-1:0] step_acc;
    logic [2*W-1:0] prod_neg;

    assign sgn_req = ~op[0];

    muldiv_abs #(.W(W)) u_abs_a (.en_signed(sgn_req), .val(src_a), .mag(mag_a), .neg(neg_a));
    muldiv_abs #(.W(W)) u_abs_b (.en_signed(sgn_req), .val(src_b), .mag(mag_b), .neg(neg_b));

    muldiv_step #(.W(W)) u_step (
        .is_div (r_q.is_div),
        .acc_i  (r_q.acc),
        .opnd   (r_q.opnd),
        .acc_o  (step_acc)
    );

    assign prod_neg = ~r_q.acc + (2*W)'(1);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_RUN;
                    r_d.cnt    = '0;
                    r_d.is_div = op[1];
                    r_d.is_sgn = sgn_req;
                    r_d.opnd   = mag_b;
                    r_d.acc    = {{W{1'b0}}, mag_a};
                    r_d.neg_lo = neg_a ^ neg_b;
                    r_d.neg_hi = op[1] ? neg_a : (neg_a ^ neg_b);
                end
            end
            ST_RUN: begin
                r_d.acc = step_acc;
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt == CW'(W - 1)) begin
                    if (r_q.is_sgn) begin
                        r_d.st = ST_FIX;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.hi   = step_acc[2*W-1:W];
                        r_d.lo   = step_acc[W-1:0];
                        r_d.done = 1'b1;
                    end
                end
            end
            ST_FIX: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
                if (r_q.is_div) begin
                    r_d.hi = r_q.neg_hi ? (~r_q.acc[2*W-1:W] + W'(1)) : r_q.acc[2*W-1:W];
                    r_d.lo = r_q.neg_lo ? (~r_q.acc[W-1:0] + W'(1)) : r_q.acc[W-1:0];
                end else if (r_q.neg_lo) begin
                    r_d.hi = prod_neg[2*W-1:W];
                    r_d.lo = prod_neg[W-1:0];
                end else begin
                    r_d.hi = r_q.acc[2*W-1:W];
                    r_d.lo = r_q.acc[W-1:0];
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != ST_IDLE);
    assign done = r_q.done;
    assign hi   = r_q.hi;
    assign lo   = r_q.lo;

    // R1: an idle unit takes a start request
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R8: busy and done never overlap
    a_r8_busy_vs_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: done lasts a single cycle and follows exactly W steps
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_step_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (r_q.cnt == CW'(W)));

    // R9: the step counter advances every running cycle regardless of start
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |=> (r_q.cnt == $past(r_q.cnt) + CW'(1)));

    // R10: result registers move only on completion
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi) && $stable(lo)));

endmodule

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
    logic        clk;
    logic        rst_n;
    logic        start;
    logic [1:0]  op;
    logic [31:0] src_a, src_b;
    logic        busy, done;
    logic [31:0] hi, lo;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;

    muldiv_unit #(.W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b),
        .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] gold(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, r;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (o)
            2'd0: return 64'(sa * sb);
            2'd1: return {32'b0, a} * {32'b0, b};
            2'd2: begin
                if (b == 0) return {a, (a[31] ? 32'd1 : 32'hFFFF_FFFF)};
                q = sa / sb;
                r = sa % sb;
                return {r[31:0], q[31:0]};
            end
            default: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                return {a % b, a / b};
            end
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] o, input logic [31:0] b);
        if (o[1] && b == 0) return "R6";
        case (o)
            2'd0: return "R3";
            2'd1: return "R2";
            2'd2: return "R5";
            default: return "R4";
        endcase
    endfunction

    // issue one operation; optionally pulse a stray start mid-run (R9)
    task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b, input bit intrude);
        logic [31:0] old_hi, old_lo;
        logic [63:0] exp;
        bit          was_done;
        int          n;
        int          lat;
        while (busy) @(negedge clk);
        was_done = done;
        old_hi = hi;
        old_lo = lo;
        exp = gold(o, a, b);
        lat = o[0] ? 33 : 34;
        op = o; src_a = a; src_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        if (was_done)
            chk(busy === 1'b1, "R11 accept in done cycle", {63'b0, busy}, 64'd1);
        else
            chk(busy === 1'b1, "R8 busy after start", {63'b0, busy}, 64'd1);
        while (!done && n < 100) begin
            if (hi !== old_hi || lo !== old_lo)
                chk(1'b0, "R10 hold during run", {hi, lo}, {old_hi, old_lo});
            if (intrude && n == 5) begin
                op = ~o; src_a = ~a; src_b = b + 32'd3; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n = n + 1;
        end
        start = 1'b0;
        chk(n == lat, intrude ? "R9 latency kept" : "R7 latency", 64'(n), 64'(lat));
        chk(busy === 1'b0, "R8 busy low with done", {63'b0, busy}, 64'd0);
        chk({hi, lo} === exp, intrude ? "R9 result kept" : req_of(o, b), {hi, lo}, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; op = 2'd0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R12 reset flags", {62'b0, busy, done}, 64'd0);
        chk({hi, lo} === 64'd0, "R12 reset regs", {hi, lo}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R3 directed
        run_op(2'd1, 32'd8, 32'd9, 1'b0);
        run_op(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op(2'd0, 32'h8000_0000, 32'h8000_0000, 1'b0);
        run_op(2'd0, 32'hFFFF_FFF9, 32'd6, 1'b0);
        // R4, R5 directed
        run_op(2'd3, 32'd74, 32'd8, 1'b0);
        run_op(2'd2, 32'hFFFF_FFF9, 32'd2, 1'b0);
        run_op(2'd2, 32'd7, 32'hFFFF_FFFE, 1'b0);
        run_op(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        // R6 zero divisor
        run_op(2'd3, 32'h1234_5678, 32'd0, 1'b0);
        run_op(2'd2, 32'h1234_5678, 32'd0, 1'b0);
        run_op(2'd2, 32'hF000_0001, 32'd0, 1'b0);
        // R9 stray start while busy
        run_op(2'd3, 32'd1000, 32'd7, 1'b1);
        run_op(2'd0, 32'hFFFF_0000, 32'd12345, 1'b1);

        // R1 random mix over every opcode, back to back (R11)
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (($urandom() % 8) == 0) rb = rb & 32'h0000_00FF;
            if (($urandom() % 16) == 0) rb = 32'd0;
            run_op(2'($urandom() % 4), ra, rb, 1'b0);
        end

        // R10: idle result registers stay put
        begin
            logic [31:0] h0, l0;
            h0 = hi; l0 = lo;
            repeat (5) @(negedge clk);
            chk(hi === h0 && lo === l0, "R10 idle hold", {hi, lo}, {h0, l0});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule